// File: doc/BRIEF.md
# Clock Multiplier Configuration Interlock

This block holds the settings that a separate clock generator needs to run its phase-locked loop. It has an 8-bit range multiplier register and a control register. The control register carries the loop enable, the base clock select and a read-only lock indication. Both registers sit on a byte-wide register bus. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the address.

Hardware interlocks keep the configuration safe:
- The multiplier cannot change while the loop is enabled.
- A multiplier of zero keeps the loop disabled and the base clock on the reference source.
- The base clock can only be switched to the loop output once the loop is enabled and reports lock.

The register values drive the multiplier, enable and select outputs directly.

Top module: `pll_range_guard`

## Requirements
- R1: After reset the multiplier reads 0x40, the loop enable is 1 and the base clock select is 0.
- R2: While the enable is 0, a write to address 0x3A loads the multiplier on that clock edge. Reading 0x3A then returns the stored byte, and it also appears on `multOut`.
- R3: While the enable is 1, a write to address 0x3A leaves the multiplier unchanged.
- R4: Address 0x36 reads as follows: bit 6 is the lock input, bit 5 the enable, bit 4 the select, and bits 7 and 3..0 read 0. Writes to 0x36 set the enable from data bit 5 and request the select with data bit 4.
- R5: Any address other than 0x36 and 0x3A reads 0x00, and a write to such an address changes no register.
- R6: While the multiplier is 0x00, the enable is held at 0, including after a write that sets data bit 5.
- R7: While the multiplier is 0x00, the select stays 0 whatever is written to it.
- R8: The select changes from 0 to 1 only on a control write with data bits 5 and 4 both 1, issued while the enable is already 1 and the lock input is 1. A select that is already 1 stays 1 on a control write with both bits 1, regardless of lock.
- R9: A control write that clears the enable also clears the select on the same edge.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data |
| lockIn | input | 1 | Lock indication from the clock generator |
| multOut | output | 8 | Range multiplier to the clock generator |
| pllEnOut | output | 1 | Loop enable to the clock generator |
| clkSelOut | output | 1 | Base clock select (1 = loop output) |

## Verification
The bench writes every multiplier value twice: once with the loop enabled, where a missing write lock would let the value through, and once with it disabled, where the value must read back exactly. After each multiplier value it tries to turn the loop on and select its output. A design without the zero-multiplier guard would then run the loop, or switch the base clock, with a multiplier of zero. It also sweeps every combination of the control bits against each reachable starting state and both lock levels. This catches a select that rises without lock, a select that survives a cleared enable, and a stray bit in the readback. Every other address is read to confirm the decode leaks nothing.

// File: rtl/pll_range_pkg.sv
package pll_range_pkg;
  // Strobes passed from the interlock control to the register datapath
  typedef struct packed {
    logic loadMult;  // multiplier write accepted this edge
    logic loadCtrl;  // control write this edge
    logic nextEn;    // enable value to load
    logic nextSel;   // select value to load
  } guard_strobe_t;
endpackage

// File: rtl/pll_range_ctrl.sv
module pll_range_ctrl
  import pll_range_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] MULT_ADDR = 8'h3A,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h36
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              dataEn,
  input  logic              dataSel,
  input  logic              lockIn,
  input  logic              curEn,
  input  logic              curSel,
  input  logic              multZero,
  output logic              hitMult,
  output logic              hitCtrl,
  output guard_strobe_t     strobe
);
  always_comb begin
    hitMult = (busAddr == MULT_ADDR);
    hitCtrl = (busAddr == CTRL_ADDR);
    // multiplier is frozen while the loop runs
    strobe.loadMult = busWrEn & hitMult & ~curEn;
    strobe.loadCtrl = busWrEn & hitCtrl;
    // a zero multiplier keeps the loop off
    strobe.nextEn   = dataEn & ~multZero;
    // select may rise only when already enabled and locked; clearing enable drops it
    strobe.nextSel  = dataEn & dataSel & ~multZero & (curSel | (curEn & lockIn));
  end
endmodule

// File: rtl/pll_range_regs.sv
module pll_range_regs
  import pll_range_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter logic [DATA_W-1:0] MULT_RESET = 8'h40,
  parameter int               EN_BIT     = 5,
  parameter int               SEL_BIT    = 4,
  parameter int               LOCK_BIT   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  guard_strobe_t     strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lockIn,
  input  logic              hitMult,
  input  logic              hitCtrl,
  output logic [DATA_W-1:0] multReg,
  output logic              enReg,
  output logic              selReg,
  output logic              multZero,
  output logic [DATA_W-1:0] rdData
);
  assign multZero = (multReg == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      multReg <= MULT_RESET;
      enReg   <= 1'b1;
      selReg  <= 1'b0;
    end else begin
      if (strobe.loadMult) multReg <= wrData;
      if (multZero) begin
        enReg  <= 1'b0;
        selReg <= 1'b0;
      end else if (strobe.loadCtrl) begin
        enReg  <= strobe.nextEn;
        selReg <= strobe.nextSel;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (hitMult) begin
      rdData = multReg;
    end else if (hitCtrl) begin
      rdData[LOCK_BIT] = lockIn;
      rdData[EN_BIT]   = enReg;
      rdData[SEL_BIT]  = selReg;
    end
  end
endmodule

// File: rtl/pll_range_guard.sv
module pll_range_guard
  import pll_range_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 8,
  parameter logic [ADDR_W-1:0] MULT_ADDR  = 8'h3A,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h36,
  parameter logic [DATA_W-1:0] MULT_RESET = 8'h40,
  parameter int               EN_BIT     = 5,
  parameter int               SEL_BIT    = 4,
  parameter int               LOCK_BIT   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              lockIn,
  output logic [DATA_W-1:0] multOut,
  output logic              pllEnOut,
  output logic              clkSelOut
);
  guard_strobe_t strobe;
  logic hitMult, hitCtrl, multZero;

  pll_range_ctrl #(
    .ADDR_W(ADDR_W), .MULT_ADDR(MULT_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .dataEn  (busWrData[EN_BIT]),
    .dataSel (busWrData[SEL_BIT]),
    .lockIn  (lockIn),
    .curEn   (pllEnOut),
    .curSel  (clkSelOut),
    .multZero(multZero),
    .hitMult (hitMult),
    .hitCtrl (hitCtrl),
    .strobe  (strobe)
  );

  pll_range_regs #(
    .DATA_W(DATA_W), .MULT_RESET(MULT_RESET),
    .EN_BIT(EN_BIT), .SEL_BIT(SEL_BIT), .LOCK_BIT(LOCK_BIT)
  ) uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (busWrData),
    .lockIn  (lockIn),
    .hitMult (hitMult),
    .hitCtrl (hitCtrl),
    .multReg (multOut),
    .enReg   (pllEnOut),
    .selReg  (clkSelOut),
    .multZero(multZero),
    .rdData  (busRdData)
  );
endmodule

// File: rtl/pll_range_guard_chk.sv
module pll_range_guard_chk #(
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 8,
  parameter logic [ADDR_W-1:0] MULT_ADDR = 8'h3A,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h36
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              lockIn,
  input logic [DATA_W-1:0] multOut,
  input logic              pllEnOut,
  input logic              clkSelOut
);
  assert_mult_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == MULT_ADDR && pllEnOut) |=> $stable(multOut));

  assert_zero_keeps_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (multOut == '0) |-> !pllEnOut);

  assert_zero_blocks_sel_R7: assert property (@(posedge clk) disable iff (!rstN)
    clkSelOut |-> (multOut != '0));

  assert_sel_needs_lock_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSelOut) |-> ($past(lockIn) && $past(pllEnOut)));

  assert_sel_follows_en_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pllEnOut |-> !clkSelOut);

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != MULT_ADDR && busAddr != CTRL_ADDR) |-> (busRdData == '0));
endmodule

bind pll_range_guard pll_range_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MULT_ADDR(MULT_ADDR), .CTRL_ADDR(CTRL_ADDR)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdData(busRdData), .lockIn(lockIn), .multOut(multOut),
  .pllEnOut(pllEnOut), .clkSelOut(clkSelOut)
);

// File: tb/sim_pll_range_guard.sv
module sim_pll_range_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MULT_A = 8'h3A;
  localparam logic [7:0] CTRL_A = 8'h36;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       lockIn = 1'b0;
  logic [7:0] multOut;
  logic       pllEnOut, clkSelOut;

  int checks = 0;
  int errors = 0;

  // bench model of the architectural state
  logic [7:0] mMult;
  logic       mEn, mSel;

  pll_range_guard u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .lockIn(lockIn),
    .multOut(multOut), .pllEnOut(pllEnOut), .clkSelOut(clkSelOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    #1 v = busRdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // compare outputs and both registers against the model
  task automatic checkState(input string req);
    logic [7:0] v;
    chk(req, "multOut", multOut, mMult);
    chk(req, "pllEnOut", pllEnOut, mEn);
    chk(req, "clkSelOut", clkSelOut, mSel);
    rd(MULT_A, v);
    chk(req, "read mult", v, mMult);
    rd(CTRL_A, v);
    chk(req, "read ctrl", v, {1'b0, lockIn, mEn, mSel, 4'b0});
  endtask

  task automatic wrMult(input logic [7:0] d);
    wr(MULT_A, d);
    if (!mEn) mMult = d;
    if (mMult == 8'h00) begin mEn = 1'b0; mSel = 1'b0; end
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    logic ns;
    wr(CTRL_A, d);
    if (mMult == 8'h00) begin
      mEn = 1'b0; mSel = 1'b0;
    end else begin
      ns = d[5] & d[4] & (mSel | (mEn & lockIn));
      mEn = d[5];
      mSel = ns;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mMult = 8'h40; mEn = 1'b1; mSel = 1'b0;

    // R1 reset values, R4 readback with both lock levels
    checkState("R1");
    lockIn = 1'b1;
    checkState("R4");
    lockIn = 1'b0;

    // R5 unmapped addresses read zero and writes there change nothing
    for (int a = 0; a < 256; a++) begin
      if (a[7:0] != MULT_A && a[7:0] != CTRL_A) begin
        rd(a[7:0], v);
        chk("R5", "unmapped read", v, 0);
      end
    end
    wr(8'h37, 8'hFF); wr(8'h3B, 8'h00); wr(8'h00, 8'hFF);
    checkState("R5");

    // R3 multiplier frozen while the loop is enabled
    for (int d = 0; d < 256; d++) begin
      wrMult(d[7:0]);
      chk("R3", "multOut while enabled", multOut, 8'h40);
    end

    // R2, R6, R7, R8, R9 per multiplier value
    for (int d = 0; d < 256; d++) begin
      lockIn = 1'b0;
      wrCtrl(8'h00);
      checkState("R9");
      wrMult(d[7:0]);
      checkState("R2");
      wrCtrl(8'h20);
      chk("R6", "enable with zero mult", pllEnOut, (d == 0) ? 0 : 1);
      lockIn = 1'b1;
      wrCtrl(8'h30);
      chk("R7", "select with zero mult", clkSelOut, (d == 0) ? 0 : 1);
      checkState("R8");
    end

    // R8/R9/R4 sweep of control bits from each reachable start state
    lockIn = 1'b0;
    wrCtrl(8'h00);
    wrMult(8'h40);
    for (int s = 0; s < 3; s++) begin
      for (int l = 0; l < 2; l++) begin
        for (int n = 0; n < 16; n++) begin
          lockIn = 1'b1;
          wrCtrl(8'h00);
          if (s >= 1) wrCtrl(8'h20);
          if (s == 2) wrCtrl(8'h30);
          checkState("R8");
          lockIn = l[0];
          wrCtrl({n[3:0], 4'hF});
          checkState((n[1] == 1'b0) ? "R9" : "R8");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule